// File: doc/BRIEF.md
# Drift-Free Periodic Interrupt Generator

This block raises a real-time interrupt flag at a fixed rate counted in raw bus clock cycles. Software picks one of four rates through a two-bit field in a control register. Each period is timed from the previous scheduled expiry and not from the moment software services the flag, so the event train never drifts, however late the handler runs. The flag sits in a shared flag register with write-one-to-clear semantics. An interrupt request output combines the flag with an enable input.

A byte-wide register port gives access to the block. Address 0 is the control register and address 1 is the flag register. Addresses 2 and 3 are reserved. A down-counter, reloaded on terminal count, forms the timebase. Writing the control register restarts the counter with the new period and does not raise the flag. A synchronous reset cancels any pending expiry and restarts timing from the lowest rate.

Top module: `rti_gen`

## Requirements
- R1: The rate field is bits [1:0] of the control register at address 0. The period is 2^BASE_LOG2 × 2^rate bus cycles, which is 8192, 16384, 32768 or 65536 at the default BASE_LOG2 = 13. Bits [7:2] of a control write are discarded and read back as 0.
- R2: After reset the rate is 0, and the flag is first set on the 2^BASE_LOG2-th clock edge after the last reset edge.
- R3: Each later expiry falls exactly one period after the previous scheduled expiry, whatever the cycle in which the flag was cleared.
- R4: A control write captured on edge W schedules the next expiry on edge W plus the new period. The write never sets the flag, even on the edge where the old schedule would have expired.
- R5: The flag is bit 6 of the flag register at address 1. Writing 1 to bit 6 clears it and writing 0 leaves it unchanged. The other bits of that register read 0.
- R6: When an expiry and a clearing write land on the same edge, the flag ends up set.
- R7: The irq output is high exactly when the flag is set and irq_en is high.
- R8: Reset clears the flag and the rate, cancels the pending expiry, and restarts timing as in R2.
- R9: Writes to addresses 2 and 3 change neither register and do not move the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the timebase |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_addr | input | 2 | Register select: 0 control, 1 flag, 2 and 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The generator runs at all four rates with a short base period. Flag clears arrive a few cycles after each expiry, which separates scheduling from the previous expiry (the correct behaviour) from scheduling from the service time. A rate write placed exactly on an edge where the old schedule would expire checks that reprogramming both suppresses the flag and restarts the count. A clear aimed at an expiry edge checks that the set wins. Writing zero to the flag bit, writing to the reserved addresses, dropping the enable and resetting mid-run each confirm that the flag and the schedule are left alone or restarted as required.

// File: rtl/rti_pkg.sv
package rti_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int RATE_W   = 2;
    localparam int N_RATES  = 1 << RATE_W;
    localparam int FLAG_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_RSV_A = 2'd2,
        SEL_RSV_B = 2'd3
    } reg_sel_e;

    typedef logic [RATE_W-1:0] rate_t;

    // Decoded write command handed from the register file to the datapath.
    typedef struct packed {
        logic  rate_wr;   // control register written this cycle
        rate_t rate_new;  // rate field of that write
        logic  flag_clr;  // write-one-to-clear hit on the flag bit
    } wr_cmd_t;

    // Counter reload value (period minus one) for a given rate.
    function automatic logic [31:0] reload_of(input int base_log2, input int rate);
        return (32'd1 << (base_log2 + rate)) - 32'd1;
    endfunction

endpackage

// File: rtl/rti_regfile.sv
module rti_regfile
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    output wr_cmd_t           cmd,
    output rate_t             rate_q,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e sel;
    logic     unused_wdata_bits;

    assign sel = reg_sel_e'(bus_addr);
    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1], bus_wdata[FLAG_BIT-1:RATE_W]};

    always_comb begin
        cmd          = '0;
        cmd.rate_new = bus_wdata[RATE_W-1:0];
        if (bus_wr) begin
            unique case (sel)
                SEL_CTRL: cmd.rate_wr  = 1'b1;
                SEL_FLAG: cmd.flag_clr = bus_wdata[FLAG_BIT];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (cmd.rate_wr) begin
            rate_q <= cmd.rate_new;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: bus_rdata[RATE_W-1:0] = rate_q;
            SEL_FLAG: bus_rdata[FLAG_BIT]   = flag;
            default:  ;
        endcase
    end

endmodule

// File: rtl/rti_countdown.sv
module rti_countdown
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    localparam int CNT_W    = BASE_LOG2 + N_RATES - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  rate_t            rate_new,
    input  rate_t            rate_cur,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic [CNT_W-1:0] reload_tbl [N_RATES];

    for (genvar r = 0; r < N_RATES; r++) begin : g_reload
        assign reload_tbl[r] = CNT_W'(reload_of(BASE_LOG2, r));
    end

    logic terminal;
    assign terminal = (count == '0);
    // A rate write wins over a terminal count: no flag on that edge.
    assign expire   = terminal && !reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= reload_tbl[0];
        end else if (reload) begin
            count <= reload_tbl[rate_new];
        end else if (terminal) begin
            count <= reload_tbl[rate_cur];
        end else begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rti_flag.sv
module rti_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rti_gen.sv
module rti_gen
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    localparam int CNT_W    = BASE_LOG2 + N_RATES - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    output logic              irq
);

    wr_cmd_t          cmd;
    rate_t            rate_q;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             flag_q;

    rti_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag_q),
        .cmd       (cmd),
        .rate_q    (rate_q),
        .bus_rdata (bus_rdata)
    );

    rti_countdown #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .reload   (cmd.rate_wr),
        .rate_new (cmd.rate_new),
        .rate_cur (rate_q),
        .count    (count_q),
        .expire   (expire)
    );

    rti_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (cmd.flag_clr),
        .flag (flag_q)
    );

    assign irq = flag_q && irq_en;

endmodule

// File: rtl/rti_gen_chk.sv
module rti_gen_chk
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    localparam int CNT_W    = BASE_LOG2 + N_RATES - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_en,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input rate_t             rate
);

    logic ctrl_wr;
    logic flag_wr;
    assign ctrl_wr = bus_wr && (bus_addr == SEL_CTRL);
    assign flag_wr = bus_wr && (bus_addr == SEL_FLAG);

    // R2 R8: timing restarts from the lowest rate after reset
    assert_reset_restart_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == CNT_W'(reload_of(BASE_LOG2, 0))) && !flag && (rate == '0));

    // R3: the counter steps down by one between scheduled events
    assert_steady_count_R3: assert property (@(posedge clk) disable iff (rst)
        (count != '0) && !ctrl_wr |=> count == $past(count) - 1'b1);

    // R1 R4: a control write reloads with the newly written period
    assert_rate_reload_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> count == CNT_W'(reload_of(BASE_LOG2, int'(rate))));

    // R4: the flag only rises after a terminal count without a control write
    assert_rise_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(count) == '0) && !$past(ctrl_wr));

    // R5: writing one clears, writing zero keeps
    assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (rst)
        flag_wr && bus_wdata[FLAG_BIT] && (count != '0) |=> !flag);
    assert_w0_keep_R5: assert property (@(posedge clk) disable iff (rst)
        flag_wr && !bus_wdata[FLAG_BIT] && flag |=> flag);

    // R6: expiry wins over a simultaneous clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        flag_wr && bus_wdata[FLAG_BIT] && (count == '0) |=> flag);

    // R7: no request while disabled
    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

bind rti_gen rti_gen_chk #(.BASE_LOG2(BASE_LOG2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_en    (irq_en),
    .irq       (irq),
    .count     (count_q),
    .flag      (flag_q),
    .rate      (rate_q)
);

// File: tb/rti_gen_test.sv
`timescale 1ns/1ps
module rti_gen_test;

    localparam int BL = 5;          // base period 32 cycles for a short run
    localparam int P0 = 1 << BL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b1;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit irq_q = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rti_gen #(.BASE_LOG2(BL)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Monitor: every irq rise must match the next scheduled edge (R2 R3 R4)
    always @(negedge clk) begin
        if (!rst && mon_on && irq && !irq_q) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R3 R4: unexpected irq rise at edge %0d, expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL R2 R3: irq rise at edge %0d, expected %0d", cyc, e);
                end
            end
        end
        irq_q = irq;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h, expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    // Write captured on edge e; returns at the negedge after it.
    task automatic wr_at(input int e, input logic [1:0] a, input logic [7:0] d);
        wait_cyc(e - 1);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd1; bus_wdata = 8'h00;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, e);
        bus_addr = 2'd1;
    endtask

    // Expect an event on edge t, then clear the flag three edges later.
    task automatic ev(input int t);
        exp_q.push_back(t);
        wr_at(t + 3, 2'd1, 8'h40);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung at edge %0d, expected completion", cyc);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 R8: reset state
        rd_chk(2'd0, 8'h00, "R8 reset ctrl");
        rd_chk(2'd1, 8'h00, "R8 reset flag");
        check("R7 reset irq", irq, 0);
        mon_on = 1'b1;

        // R2 first event, R3 steady spacing at rate 0
        ev(P0);
        ev(2 * P0);

        // R5: writing zero to the flag bit keeps it, writing one clears it
        exp_q.push_back(3 * P0);
        wr_at(98, 2'd1, 8'hBF);
        rd_chk(2'd1, 8'h40, "R5 write zero keeps");
        wr_at(100, 2'd1, 8'h40);
        rd_chk(2'd1, 8'h00, "R5 write one clears");

        // R9: reserved addresses ignored; schedule unchanged
        wr_at(102, 2'd2, 8'hFF);
        wr_at(103, 2'd3, 8'hFF);
        rd_chk(2'd0, 8'h00, "R9 ctrl untouched");
        rd_chk(2'd1, 8'h00, "R9 flag untouched");
        ev(128);

        // R4: rate write mid-period restarts timing, no flag
        wr_at(140, 2'd0, 8'h02);
        rd_chk(2'd1, 8'h00, "R4 no flag on rate write");
        rd_chk(2'd0, 8'h02, "R1 rate readback");
        ev(268);
        // R4: rate write on the edge of an old expiry (396) suppresses it
        wr_at(396, 2'd0, 8'h01);
        rd_chk(2'd1, 8'h00, "R4 write on expiry edge");
        ev(460);
        ev(524);

        // R1: upper control bits dropped
        wr_at(530, 2'd0, 8'hFE);
        rd_chk(2'd0, 8'h02, "R1 upper bits ignored");
        ev(658);
        wr_at(700, 2'd0, 8'h03);
        ev(956);
        ev(1212);

        // R6: clear on an expiry edge loses to the set
        exp_q.push_back(1468);
        wr_at(1468, 2'd1, 8'h40);
        rd_chk(2'd1, 8'h40, "R6 set wins");
        wr_at(1471, 2'd1, 8'h40);

        // R7: enable gating
        wait_cyc(1480);
        irq_en = 1'b0;
        mon_on = 1'b0;
        wait_cyc(1725);
        check("R7 irq masked", irq, 0);
        rd_chk(2'd1, 8'h40, "R7 flag still set");
        irq_en = 1'b1;
        #1;
        check("R7 irq follows flag", irq, 1);
        wr_at(1730, 2'd1, 8'h40);
        check("R7 irq after clear", irq, 0);
        mon_on = 1'b1;

        // R8: mid-run reset restarts from rate 0
        wait_cyc(1800);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_chk(2'd0, 8'h00, "R8 rate cleared");
        rd_chk(2'd1, 8'h00, "R8 flag cleared");
        ev(P0);
        wait_cyc(P0 + 10);
        check("R3 all events seen", exp_q.size(), 0);
        summary();
    end

endmodule